// File: doc/BRIEF.md
# Half-Duplex Command/Response Serial Slave

This block is a serial-peripheral slave that uses one shared data line in both directions. A transaction opens when the active-low select goes low. The master then clocks in a command of fixed length. The slave captures it and presents it as one wide word with a one-cycle valid strobe. Once the last command bit is in, the slave turns the line around without being told to. It enables its output driver and returns a fixed-length response taken from a small buffer that local logic writes ahead of time.

The serial clock idles low. Both sides sample on the rising edge, and the slave moves its output bit after the falling edge. The select line, the serial clock and the data pin all pass through two-flop synchronisers into the system clock domain, and all edge detection runs there. The master may stop the clock between the two phases for as long as it likes while select stays low. If select rises before the exchange is finished, the block discards every partial count and shift register. It flags the abort for one cycle and starts the next transaction clean.

Top module: `hd_spi_slave`

## Requirements
- R1: After synchronous reset, `sdio_oe`, `cmd_valid_o`, `done_o` and `abort_o` are all 0.
- R2: While select is low in the command phase, each rising serial-clock edge samples one data bit, most-significant bit first. After CMD_BYTES*WORD_W rising edges, `cmd_valid_o` is 1 for exactly one system cycle. In that same cycle `cmd_o` holds the command, with the first byte received in its most-significant byte.
- R3: `sdio_oe` is 0 in the command phase and whenever select is high. It is 1 from the end of the command until the last response bit has been clocked.
- R4: The response is sent from buffer address 0 upward, each byte most-significant bit first. The first bit is on `sdio_o` before the first response rising edge. Each later bit appears after the falling edge that follows the rising edge which sampled the previous bit.
- R5: If the serial clock stops for any time between the phases with select held low, no state changes: the driver stays on and the first response bit stays on `sdio_o`.
- R6: After the last response rising edge, `done_o` is 1 for exactly one cycle and `sdio_oe` returns to 0.
- R7: If select rises during the command or response phase, `abort_o` is 1 for exactly one cycle, and neither `cmd_valid_o` nor `done_o` is raised for that transaction. The next transaction behaves as if no abort had happened.
- R8: If select rises after `done_o`, `abort_o` stays 0.
- R9: A write on the buffer port (`rsp_we_i`, `rsp_addr_i`, `rsp_wdata_i`) stores one byte. The last value written to an address before select falls is the value sent from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from master, idles low |
| cs_n_i | input | 1 | Active-low select from master |
| sdio_i | input | 1 | Input side of the shared data pin |
| sdio_o | output | 1 | Output side of the shared data pin |
| sdio_oe | output | 1 | Output enable of the shared data pin |
| cmd_o | output | CMD_BYTES*WORD_W | Last complete command, first byte in the top bits |
| cmd_valid_o | output | 1 | One-cycle strobe when a command completes |
| rsp_we_i | input | 1 | Response buffer write enable |
| rsp_addr_i | input | addr_w(RSP_BYTES) | Response buffer byte address |
| rsp_wdata_i | input | WORD_W | Response buffer write data |
| done_o | output | 1 | One-cycle strobe when the full response has been sent |
| abort_o | output | 1 | One-cycle strobe on an early deselect |

## Verification
The bench builds the block with CMD_BYTES=3, RSP_BYTES=4 and WORD_W=8. With phases that short, it can drop select at every command bit position from zero to the last, and at a stride of positions across the response. It still has time for several complete transactions with different byte patterns, one of them with a long clock pause at the turnaround. Each complete transaction first writes a decoy pattern to the buffer and then the real one, so the last-write-wins rule is exercised every time.

// File: rtl/hd_spi_pkg.sv
package hd_spi_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_RSP  = 2'd2,
    PH_FIN  = 2'd3
  } phase_e;

  function automatic int addr_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/hd_spi_sync.sv
module hd_spi_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign level_o[g] = stab_q;
  end

endmodule

// File: rtl/hd_spi_cmd_rx.sv
module hd_spi_cmd_rx #(
  parameter int BYTES  = 10,
  parameter int WORD_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      shift_en,
  input  logic                      bit_i,
  output logic [BYTES*WORD_W-1:0]   next_word_o,
  output logic                      last_o
);

  localparam int TOT = BYTES * WORD_W;
  localparam int TW  = $clog2(TOT + 1);

  logic [TOT-1:0] shreg_q;
  logic [TW-1:0]  cnt_q;

  assign next_word_o = {shreg_q[TOT-2:0], bit_i};
  assign last_o      = shift_en && (cnt_q == TW'(TOT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (shift_en) begin
      shreg_q <= next_word_o;
      cnt_q   <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R2
  cmd_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < TW'(TOT));

  // R7
  cmd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/hd_spi_rsp_tx.sv
module hd_spi_rsp_tx import hd_spi_pkg::*; #(
  parameter int BYTES  = 10,
  parameter int WORD_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [addr_w(BYTES)-1:0]   wr_addr,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic                       hold,
  input  logic                       rise_en,
  input  logic                       fall_en,
  output logic                       bit_o,
  output logic                       last_o
);

  localparam int AW  = addr_w(BYTES);
  localparam int TOT = BYTES * WORD_W;
  localparam int TW  = $clog2(TOT + 1);
  localparam int BW  = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] mem [BYTES];
  logic [WORD_W-1:0] rd_data_q;
  logic [AW-1:0]     rd_addr_q;
  logic              hold_q;
  logic [WORD_W-1:0] shreg_q;
  logic [BW-1:0]     bitc_q;
  logic [TW-1:0]     tot_q;
  logic              armed_q;
  logic              load;

  // buffer: write port and registered read port
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < BYTES)) mem[wr_addr] <= wr_data;
    rd_data_q <= mem[rd_addr_q];
  end

  assign load   = fall_en && armed_q && (bitc_q == '0);
  assign last_o = rise_en && (tot_q == TW'(TOT - 1));
  assign bit_o  = shreg_q[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= 1'b1;
      rd_addr_q <= '0;
    end else begin
      hold_q <= hold;
      if (hold)
        rd_addr_q <= '0;
      else if (hold_q)
        rd_addr_q <= (BYTES > 1) ? AW'(1) : '0;
      else if (load && (rd_addr_q != AW'(BYTES - 1)))
        rd_addr_q <= rd_addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      bitc_q  <= '0;
      tot_q   <= '0;
      armed_q <= 1'b0;
    end else if (hold) begin
      shreg_q <= rd_data_q;
      bitc_q  <= '0;
      tot_q   <= '0;
      armed_q <= 1'b0;
    end else if (rise_en) begin
      armed_q <= 1'b1;
      bitc_q  <= (bitc_q == BW'(WORD_W - 1)) ? '0 : bitc_q + 1'b1;
      tot_q   <= tot_q + 1'b1;
    end else if (fall_en && armed_q) begin
      armed_q <= 1'b0;
      shreg_q <= load ? rd_data_q : {shreg_q[WORD_W-2:0], 1'b0};
    end
  end

  // R5
  tx_pause_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !rise_en && !fall_en) |=> $stable(shreg_q));

  // R4
  tx_fall_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && fall_en && !armed_q && !rise_en) |=> $stable(shreg_q));

endmodule

// File: rtl/hd_spi_slave.sv
module hd_spi_slave import hd_spi_pkg::*; #(
  parameter int CMD_BYTES = 10,
  parameter int RSP_BYTES = 10,
  parameter int WORD_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            sclk_i,
  input  logic                            cs_n_i,
  input  logic                            sdio_i,
  output logic                            sdio_o,
  output logic                            sdio_oe,
  output logic [CMD_BYTES*WORD_W-1:0]     cmd_o,
  output logic                            cmd_valid_o,
  input  logic                            rsp_we_i,
  input  logic [addr_w(RSP_BYTES)-1:0]    rsp_addr_i,
  input  logic [WORD_W-1:0]               rsp_wdata_i,
  output logic                            done_o,
  output logic                            abort_o
);

  localparam int CMD_BITS = CMD_BYTES * WORD_W;

  logic [2:0]          pin_lvl;
  logic                cs_low, sclk_lvl, data_lvl, sclk_q;
  logic                sclk_rise, sclk_fall;
  phase_e              phase_q, phase_d;
  logic                cv_d, dn_d, ab_d;
  logic [CMD_BITS-1:0] cmd_next;
  logic                cmd_last, tx_last, tx_bit;

  hd_spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({cs_n_i, sclk_i, sdio_i}),
    .level_o (pin_lvl)
  );

  assign cs_low   = ~pin_lvl[2];
  assign sclk_lvl = pin_lvl[1];
  assign data_lvl = pin_lvl[0];

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_lvl;
  end

  assign sclk_rise = sclk_lvl & ~sclk_q;
  assign sclk_fall = ~sclk_lvl & sclk_q;

  hd_spi_cmd_rx #(.BYTES(CMD_BYTES), .WORD_W(WORD_W)) u_cmd (
    .clk         (clk),
    .rst         (rst),
    .clr         (phase_q != PH_CMD),
    .shift_en    ((phase_q == PH_CMD) && cs_low && sclk_rise),
    .bit_i       (data_lvl),
    .next_word_o (cmd_next),
    .last_o      (cmd_last)
  );

  hd_spi_rsp_tx #(.BYTES(RSP_BYTES), .WORD_W(WORD_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rsp_we_i),
    .wr_addr (rsp_addr_i),
    .wr_data (rsp_wdata_i),
    .hold    (phase_q != PH_RSP),
    .rise_en ((phase_q == PH_RSP) && cs_low && sclk_rise),
    .fall_en ((phase_q == PH_RSP) && cs_low && sclk_fall),
    .bit_o   (tx_bit),
    .last_o  (tx_last)
  );

  always_comb begin
    phase_d = phase_q;
    cv_d    = 1'b0;
    dn_d    = 1'b0;
    ab_d    = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (cs_low) phase_d = PH_CMD;
      PH_CMD: begin
        if (!cs_low) begin
          ab_d    = 1'b1;
          phase_d = PH_IDLE;
        end else if (cmd_last) begin
          cv_d    = 1'b1;
          phase_d = PH_RSP;
        end
      end
      PH_RSP: begin
        if (!cs_low) begin
          ab_d    = 1'b1;
          phase_d = PH_IDLE;
        end else if (tx_last) begin
          dn_d    = 1'b1;
          phase_d = PH_FIN;
        end
      end
      PH_FIN: if (!cs_low) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      sdio_oe     <= 1'b0;
      cmd_valid_o <= 1'b0;
      done_o      <= 1'b0;
      abort_o     <= 1'b0;
      cmd_o       <= '0;
    end else begin
      phase_q     <= phase_d;
      sdio_oe     <= (phase_d == PH_RSP);
      cmd_valid_o <= cv_d;
      done_o      <= dn_d;
      abort_o     <= ab_d;
      if (cv_d) cmd_o <= cmd_next;
    end
  end

  assign sdio_o = tx_bit;

  // R3
  oe_off_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_low |=> !sdio_oe);

  // R2
  cmd_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);

  // R6
  done_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  done_oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !sdio_oe);

  // R7
  abort_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (!cmd_valid_o && !done_o && !sdio_oe));

  // R8
  fin_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FIN) |=> !abort_o);

endmodule

// File: tb/test_hd_spi_slave.sv
module test_hd_spi_slave;
  import hd_spi_pkg::*;

  localparam int CB = 3;
  localparam int RB = 4;
  localparam int W  = 8;
  localparam int CT = CB * W;
  localparam int RT = RB * W;
  localparam int AW = addr_w(RB);
  localparam int H  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic          sdo, oe, cv, dn, ab;
  logic [CT-1:0] cmd;
  logic          we = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic [W-1:0]  wdata = '0;

  int n_chk = 0, n_bad = 0;
  int n_cv = 0, n_dn = 0, n_ab = 0;

  always #10 clk = ~clk;

  hd_spi_slave #(.CMD_BYTES(CB), .RSP_BYTES(RB), .WORD_W(W)) i_hd_spi_slave (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe(oe), .cmd_o(cmd), .cmd_valid_o(cv),
    .rsp_we_i(we), .rsp_addr_i(waddr), .rsp_wdata_i(wdata),
    .done_o(dn), .abort_o(ab)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (cv) n_cv++;
      if (dn) n_dn++;
      if (ab) n_ab++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [CT-1:0] mk_cmd(input int t);
    logic [CT-1:0] v;
    for (int i = 0; i < CB; i++) v[CT-1-W*i -: W] = W'((t * 37 + i * 11 + 5) ^ (t << 4));
    return v;
  endfunction

  function automatic logic [RT-1:0] mk_rsp(input int t);
    logic [RT-1:0] v;
    for (int i = 0; i < RB; i++) v[RT-1-W*i -: W] = W'((t * 53 + i * 29 + 163) ^ (i << 5));
    return v;
  endfunction

  task automatic load_buf(input logic [RT-1:0] v);
    for (int i = 0; i < RB; i++) begin
      we = 1'b1; waddr = AW'(i); wdata = v[RT-1-W*i -: W];
      step(1);
    end
    we = 1'b0;
    step(1);
  endtask

  // cab / rab: bit index at which select rises early, -1 for none
  task automatic xfer(input int t, input int cab, input int rab, input int pause);
    logic [CT-1:0] c;
    logic [RT-1:0] r;
    bit aborted;
    c = mk_cmd(t);
    r = mk_rsp(t);
    aborted = 0;
    load_buf(mk_rsp(t + 100));
    load_buf(r);                       // R9: last write wins
    n_cv = 0; n_dn = 0; n_ab = 0;
    cs_n = 1'b0;
    step(H);
    for (int b = 0; b < CT; b++) begin
      if (b == cab) begin aborted = 1; break; end
      sdi = c[CT-1-b];
      step(H);
      @(negedge clk);
      chk("R3 oe in command", 64'(oe), 64'd0);
      sclk = 1'b1;
      step(H);
      sclk = 1'b0;
    end
    if (!aborted) begin
      step(H + pause);
      @(negedge clk);
      chk("R2 valid count", 64'(n_cv), 64'd1);
      chk("R2 command word", 64'(cmd), 64'(c));
      chk("R3 oe in response", 64'(oe), 64'd1);
      if (pause > 0) chk("R5 first bit after pause", 64'(sdo), 64'(r[RT-1]));
      for (int b = 0; b < RT; b++) begin
        if (b == rab) begin aborted = 1; break; end
        @(negedge clk);
        chk("R4 response bit", 64'(sdo), 64'(r[RT-1-b]));
        sclk = 1'b1;
        step(H);
        sclk = 1'b0;
        step(H);
      end
      if (!aborted) begin
        @(negedge clk);
        chk("R6 done count", 64'(n_dn), 64'd1);
        chk("R6 oe released", 64'(oe), 64'd0);
      end
    end
    cs_n = 1'b1;
    step(8);
    @(negedge clk);
    if (aborted) begin
      chk("R7 abort pulse", 64'(n_ab), 64'd1);
      chk("R7 no done", 64'(n_dn), 64'd0);
      if (cab >= 0) chk("R7 no valid", 64'(n_cv), 64'd0);
    end else begin
      chk("R8 no abort after done", 64'(n_ab), 64'd0);
    end
    chk("R3 oe deselected", 64'(oe), 64'd0);
    step(H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(5);
    rst = 1'b0;
    step(3);
    @(negedge clk);
    chk("R1 oe", 64'(oe), 64'd0);
    chk("R1 valid", 64'(cv), 64'd0);
    chk("R1 done", 64'(dn), 64'd0);
    chk("R1 abort", 64'(ab), 64'd0);
    step(1);
    for (int t = 0; t < 3; t++) xfer(t, -1, -1, 0);
    xfer(7, -1, -1, 400);                       // R5 long pause
    for (int k = 0; k < CT; k++) xfer(10 + k, k, -1, 0);   // R7 command aborts
    xfer(50, -1, -1, 0);
    for (int k = 0; k < RT; k += 3) xfer(60 + k, -1, k, 0); // R7 response aborts
    xfer(99, -1, -1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule